// File: doc/BRIEF.md
# Dual Down-Counting Timer with Shared Prescaler

This block holds two 8-bit down-counters that share one control word, and one programmable prescaler. Each counter has four settings: a reload divider, a run/hold mode, an acknowledge bit for its interrupt, and a tick-source select. A counter can take its ticks from one of two fixed-rate tick-enable inputs or from the prescaler output. The second counter can also take one tick for each underflow of the first, so the two chain into one longer period.

When a running counter sits at 1 and receives a tick, it underflows. It then reloads its divider and raises a sticky interrupt flag, which software clears through the control word. The prescaler counts down once per system clock and emits a one-cycle tick when it wraps. Software can read back both counters and the live prescaler value, and can combine them into a time stamp finer than one interrupt period. All logic runs in one clock domain.

Top module: `dual_timer`

## Requirements
- R1: After reset, both counters, both interrupt flags, the prescaler reload value and the prescaler count read as zero.
- R2: Control bit 10 (timer 0) or bit 26 (timer 1) set to 0 selects hold mode. In hold mode the counter loads its divider (bits 7:0 or 23:16) on every clock and ignores ticks.
- R3: In run mode (mode bit 1) a counter decrements once per tick of its selected source. The select field is bits 9:8 or 25:24: 0 = input tick_a, 1 = input tick_b, 2 = prescaler tick, 3 = no source for timer 0.
- R4: A running counter at 1 that receives a tick underflows. It reloads its divider and sets its sticky interrupt flag. The interrupt period is therefore the divider value in ticks.
- R5: A divider of 0 acts as 256 ticks.
- R6: A control write with the acknowledge bit (bit 11 or 27) at 1 clears that timer's flag. With the bit at 0 the flag is left unchanged. An underflow in the same cycle wins over the clear.
- R7: Select code 3 on timer 1 is cascade mode: timer 1 decrements once per timer 0 underflow and at no other time.
- R8: The prescaler counts down once per clock from its reload value. At 0 it emits one tick and reloads, so the tick period is reload+1 clocks. A write to address 1 sets the reload value from bits 15:0 and loads the count at once.
- R9: Reads are combinational. Address 0 returns {timer1 count, timer0 count} in bits 15:0, address 1 the prescaler reload value, address 2 the live prescaler count, and address 3 the flags (bit 0 timer 0, bit 1 timer 1). Writes to addresses 2 and 3 change nothing.
- R10: With a tick every clock and a divider of 250, timer 0 sets its flag exactly 250 clocks after it enters run mode from hold.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |
| tick_a | input | 1 | Fixed-rate tick enable A |
| tick_b | input | 1 | Fixed-rate tick enable B |
| irq0 | output | 1 | Timer 0 sticky interrupt flag |
| irq1 | output | 1 | Timer 1 sticky interrupt flag |

## Verification
A wrong count or a wrong reload shows up in the counter readback on the next clock. It also moves the next interrupt edge by the same number of ticks, and in cascade mode the error spreads into timer 1's period. A prescaler that is off by one makes the live count read wrong within one clock of a write, and every flexible-clocked period drifts after that. The bench compares every readable register and both flags against its own cycle model on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    SRC_TICK_A = 2'd0,
    SRC_TICK_B = 2'd1,
    SRC_FLEX   = 2'd2,
    SRC_AUX    = 2'd3
  } tsrc_e;

  typedef enum logic [1:0] {
    ADR_CTRL   = 2'd0,
    ADR_PSC    = 2'd1,
    ADR_PSC_LV = 2'd2,
    ADR_FLAGS  = 2'd3
  } tadr_e;

  localparam int SLOT_W = 16;
endpackage

// File: rtl/psc_unit.sv
module psc_unit #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [PW-1:0] ld_val,
  output logic          tick,
  output logic [PW-1:0] cnt_o,
  output logic [PW-1:0] reload_o
);
  logic [PW-1:0] cnt_q, rel_q;

  assign tick     = (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign reload_o = rel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else if (ld) begin
      cnt_q <= ld_val;
      rel_q <= ld_val;
    end else if (tick) begin
      cnt_q <= rel_q;
    end else begin
      cnt_q <= cnt_q - PW'(1);
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import timer_pkg::*;
#(
  parameter int TW       = 8,
  parameter bit HAS_CASC = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [TW+3:0] cfg_in,
  input  logic          tick_a,
  input  logic          tick_b,
  input  logic          tick_flex,
  input  logic          tick_casc,
  output logic [TW-1:0] cnt_o,
  output logic [TW-1:0] div_o,
  output logic          run_o,
  output tsrc_e         src_o,
  output logic          uf_o,
  output logic          irq_o
);
  localparam int RUN_B = TW + 2;
  localparam int ACK_B = TW + 3;

  logic [TW-1:0] cnt_q, div_q;
  logic          run_q, irq_q, tick, aux_tick;
  tsrc_e         src_q;

  function automatic logic [TW-1:0] next_cnt(input logic [TW-1:0] c,
                                             input logic [TW-1:0] d,
                                             input logic r, input logic t);
    if (!r)              return d;
    if (!t)              return c;
    if (c == TW'(1))     return d;
    return c - TW'(1);
  endfunction

  generate
    if (HAS_CASC) begin : g_casc
      assign aux_tick = tick_casc;
    end else begin : g_nocasc
      assign aux_tick = 1'b0;
    end
  endgenerate

  always_comb begin
    case (src_q)
      SRC_TICK_A: tick = tick_a;
      SRC_TICK_B: tick = tick_b;
      SRC_FLEX:   tick = tick_flex;
      default:    tick = aux_tick;
    endcase
  end

  assign uf_o  = run_q && tick && (cnt_q == TW'(1));
  assign cnt_o = cnt_q;
  assign div_o = div_q;
  assign run_o = run_q;
  assign src_o = src_q;
  assign irq_o = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
      src_q <= SRC_TICK_A;
    end else begin
      cnt_q <= next_cnt(cnt_q, div_q, run_q, tick);
      if (uf_o)
        irq_q <= 1'b1;
      else if (cfg_wr && cfg_in[ACK_B])
        irq_q <= 1'b0;
      if (cfg_wr) begin
        div_q <= cfg_in[TW-1:0];
        src_q <= tsrc_e'(cfg_in[TW+1:TW]);
        run_q <= cfg_in[RUN_B];
      end
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import timer_pkg::*;
#(
  parameter int TW = 8,
  parameter int PW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          tick_a,
  input  logic          tick_b,
  output logic          irq0,
  output logic          irq1
);
  localparam int CW = TW + 4;
  localparam int NT = 2;

  logic          ctrl_wr, psc_wr, p_tick;
  logic [PW-1:0] psc_cnt, psc_rel;
  logic [TW-1:0] cnt_a [NT];
  logic [TW-1:0] div_a [NT];
  logic          run_a [NT];
  tsrc_e         src_a [NT];
  logic          uf_a  [NT];
  logic          irq_a [NT];

  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
  assign psc_wr  = wr_en && (wr_addr == ADR_PSC);

  psc_unit #(.PW(PW)) u_psc (
    .clk(clk), .rst_n(rst_n), .ld(psc_wr), .ld_val(wr_data[PW-1:0]),
    .tick(p_tick), .cnt_o(psc_cnt), .reload_o(psc_rel)
  );

  generate
    for (genvar i = 0; i < NT; i++) begin : g_tmr
      tmr_unit #(.TW(TW), .HAS_CASC(i > 0)) u_tmr (
        .clk(clk), .rst_n(rst_n), .cfg_wr(ctrl_wr),
        .cfg_in(wr_data[i*SLOT_W +: CW]),
        .tick_a(tick_a), .tick_b(tick_b), .tick_flex(p_tick),
        .tick_casc(uf_a[0]),
        .cnt_o(cnt_a[i]), .div_o(div_a[i]), .run_o(run_a[i]),
        .src_o(src_a[i]), .uf_o(uf_a[i]), .irq_o(irq_a[i])
      );
    end
  endgenerate

  // named internal events for the checker
  logic [TW-1:0] cnt0, cnt1, div0;
  logic          run0, run1, uf0, uf1, ack0_wr, ack1_wr;
  tsrc_e         src1;
  assign cnt0    = cnt_a[0];
  assign cnt1    = cnt_a[1];
  assign div0    = div_a[0];
  assign run0    = run_a[0];
  assign run1    = run_a[1];
  assign src1    = src_a[1];
  assign uf0     = uf_a[0];
  assign uf1     = uf_a[1];
  assign ack0_wr = ctrl_wr && wr_data[TW+3];
  assign ack1_wr = ctrl_wr && wr_data[SLOT_W+TW+3];

  assign irq0 = irq_a[0];
  assign irq1 = irq_a[1];

  always_comb begin
    case (rd_addr)
      ADR_CTRL:   rd_data = DW'({cnt_a[1], cnt_a[0]});
      ADR_PSC:    rd_data = DW'(psc_rel);
      ADR_PSC_LV: rd_data = DW'(psc_cnt);
      default:    rd_data = DW'({irq_a[1], irq_a[0]});
    endcase
  end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import timer_pkg::*;
#(
  parameter int TW = 8,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq0,
  input logic          irq1,
  input logic          uf0,
  input logic          uf1,
  input logic          ack0_wr,
  input logic          ack1_wr,
  input logic          run0,
  input logic          run1,
  input logic [TW-1:0] cnt0,
  input logic [TW-1:0] cnt1,
  input logic [TW-1:0] div0,
  input tsrc_e         src1,
  input logic          p_tick,
  input logic          psc_wr,
  input logic [PW-1:0] psc_cnt,
  input logic [PW-1:0] psc_rel
);
  // R4
  irq0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq0) |-> $past(uf0));
  // R4
  irq1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq1) |-> $past(uf1));
  // R6
  irq0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq0) |-> $past(ack0_wr));
  // R6
  irq1_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq1) |-> $past(ack1_wr));
  // R2
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && $past(!run0) && $stable(div0)) |-> (cnt0 == div0));
  // R7
  casc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run1 && src1 == SRC_AUX && !uf0) |=> $stable(cnt1));
  // R8
  psc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_tick && !psc_wr) |=> (psc_cnt == $past(psc_rel)));
endmodule

bind dual_timer dual_timer_chk #(.TW(TW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq0(irq0), .irq1(irq1), .uf0(uf0), .uf1(uf1),
  .ack0_wr(ack0_wr), .ack1_wr(ack1_wr), .run0(run0), .run1(run1),
  .cnt0(cnt0), .cnt1(cnt1), .div0(div0), .src1(src1), .p_tick(p_tick),
  .psc_wr(psc_wr), .psc_cnt(psc_cnt), .psc_rel(psc_rel)
);

// File: tb/tb_dual_timer.sv
`timescale 1ns/1ps
module tb_dual_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tick_a = 1'b0, tick_b = 1'b0;
  logic        irq0, irq1;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  dual_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_a(tick_a), .tick_b(tick_b), .irq0(irq0), .irq1(irq1));

  always #2.5 clk = ~clk;

  // bench cycle model, built from the requirements
  logic [7:0]  m_cnt [2];
  logic [7:0]  m_div [2];
  logic        m_run [2];
  logic [1:0]  m_sel [2];
  logic        m_irq [2];
  logic [15:0] m_pv, m_pc;

  function automatic logic src_tick(input logic [1:0] s, input logic a, b, f, x);
    case (s)
      2'd0: return a;
      2'd1: return b;
      2'd2: return f;
      default: return x;
    endcase
  endfunction

  function automatic logic [7:0] step_cnt(input logic [7:0] c, d, input logic r, t);
    if (!r) return d;
    if (!t) return c;
    return (c == 8'd1) ? d : c - 8'd1;
  endfunction

  always @(posedge clk) begin
    logic pt, t0, t1, u0, u1, cw;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_div[i] = 0; m_run[i] = 0; m_sel[i] = 0; m_irq[i] = 0;
      end
      m_pv = 0; m_pc = 0;
    end else begin
      pt = (m_pc == 16'd0);
      t0 = src_tick(m_sel[0], tick_a, tick_b, pt, 1'b0);
      u0 = m_run[0] && t0 && m_cnt[0] == 8'd1;
      t1 = src_tick(m_sel[1], tick_a, tick_b, pt, u0);
      u1 = m_run[1] && t1 && m_cnt[1] == 8'd1;
      m_cnt[0] = step_cnt(m_cnt[0], m_div[0], m_run[0], t0);
      m_cnt[1] = step_cnt(m_cnt[1], m_div[1], m_run[1], t1);
      cw = wr_en && wr_addr == 2'd0;
      if (u0) m_irq[0] = 1; else if (cw && wr_data[11]) m_irq[0] = 0;
      if (u1) m_irq[1] = 1; else if (cw && wr_data[27]) m_irq[1] = 0;
      if (wr_en && wr_addr == 2'd1) begin
        m_pv = wr_data[15:0]; m_pc = wr_data[15:0];
      end else m_pc = pt ? m_pv : m_pc - 16'd1;
      if (cw) begin
        m_div[0] = wr_data[7:0];   m_sel[0] = wr_data[9:8];   m_run[0] = wr_data[10];
        m_div[1] = wr_data[23:16]; m_sel[1] = wr_data[25:24]; m_run[1] = wr_data[26];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_read(input logic [1:0] a);
    case (a)
      2'd0: return {16'd0, m_cnt[1], m_cnt[0]};
      2'd1: return {16'd0, m_pv};
      2'd2: return {16'd0, m_pc};
      default: return {30'd0, m_irq[1], m_irq[0]};
    endcase
  endfunction

  // one clock; at the next falling edge compare against the model (R9)
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == mdl_read(rd_addr), "R9", rd_data, mdl_read(rd_addr));
    chk({irq1, irq0} == {m_irq[1], m_irq[0]}, "R4", {irq1, irq0}, {m_irq[1], m_irq[0]});
  endtask

  function automatic logic [15:0] fld(input logic [7:0] d, input logic [1:0] s,
                                      input logic r, input logic a);
    return {4'd0, a, r, s, d};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic rd_now(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #0.1; v = rd_data;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd_now(a[1:0], v);
      chk(v == 32'd0, "R1", v, 32'd0);
    end
    chk({irq1, irq0} == 2'b00, "R1", {irq1, irq0}, 0);

    // R2: hold mode loads divider and ignores ticks
    tick_a = 1;
    wr(2'd0, {fld(8'd9, 2'd0, 0, 0), fld(8'd77, 2'd0, 0, 0)});
    repeat (4) cyc();
    rd_now(2'd0, v);
    chk(v[15:0] == 16'h094D, "R2", v, 32'h094D);

    // R10 + R4: div 250, tick every clock
    wr(2'd0, {fld(8'd0, 2'd0, 0, 1), fld(8'd250, 2'd0, 0, 1)});
    cyc();
    wr(2'd0, {fld(8'd0, 2'd0, 0, 0), fld(8'd250, 2'd0, 1, 0)});
    n = 0;
    while (!irq0 && n < 400) begin cyc(); n++; end
    chk(n == 250, "R10", n, 250);
    rd_now(2'd0, v);
    chk(v[7:0] == 8'd250, "R4", v[7:0], 250);

    // R6: ack at 0 leaves flag, ack at 1 clears it
    wr(2'd0, {fld(8'd0, 2'd0, 0, 0), fld(8'd250, 2'd0, 1, 0)});
    chk(irq0 == 1'b1, "R6", irq0, 1);
    wr(2'd0, {fld(8'd0, 2'd0, 0, 0), fld(8'd250, 2'd0, 1, 1)});
    chk(irq0 == 1'b0, "R6", irq0, 0);

    // R5: divider 0 gives 256 ticks
    wr(2'd0, {fld(8'd0, 2'd0, 0, 0), fld(8'd0, 2'd0, 0, 1)});
    cyc();
    wr(2'd0, {fld(8'd0, 2'd0, 0, 0), fld(8'd0, 2'd0, 1, 0)});
    n = 0;
    while (!irq0 && n < 400) begin cyc(); n++; end
    chk(n == 256, "R5", n, 256);

    // R3: source tick_b idle while tick_a runs -> no movement; timer0 code 3 has no source
    wr(2'd0, {fld(8'd0, 2'd0, 0, 1), fld(8'd20, 2'd1, 0, 1)});
    cyc();
    wr(2'd0, {fld(8'd0, 2'd0, 0, 0), fld(8'd20, 2'd1, 1, 0)});
    tick_b = 0;
    repeat (5) cyc();
    rd_now(2'd0, v);
    chk(v[7:0] == 8'd20, "R3", v[7:0], 20);
    tick_b = 1;
    repeat (3) cyc();
    rd_now(2'd0, v);
    chk(v[7:0] == 8'd17, "R3", v[7:0], 17);
    wr(2'd0, {fld(8'd0, 2'd0, 0, 0), fld(8'd20, 2'd3, 1, 0)});
    repeat (5) cyc();
    rd_now(2'd0, v);
    chk(v[7:0] == 8'd16, "R3", v[7:0], 16);

    // R7: cascade, timer0 div 3, timer1 div 2 -> timer1 flag after 6 ticks
    wr(2'd0, {fld(8'd2, 2'd3, 0, 1), fld(8'd3, 2'd0, 0, 1)});
    cyc();
    wr(2'd0, {fld(8'd2, 2'd3, 1, 0), fld(8'd3, 2'd0, 1, 0)});
    n = 0;
    while (!irq1 && n < 50) begin cyc(); n++; end
    chk(n == 6, "R7", n, 6);
    rd_now(2'd0, v);
    chk(v[15:8] == 8'd2, "R7", v[15:8], 2);

    // R8: prescaler load and countdown
    wr(2'd1, 32'd4);
    rd_now(2'd2, v);
    chk(v == 32'd4, "R8", v, 4);
    cyc();
    rd_now(2'd2, v);
    chk(v == 32'd3, "R8", v, 3);
    repeat (4) cyc();
    rd_now(2'd2, v);
    chk(v == 32'd4, "R8", v, 4);
    // R9: writes to address 2 and 3 change nothing
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd_now(2'd1, v);
    chk(v == 32'd4, "R9", v, 4);

    // constrained random phase, checked every clock against the model
    for (int k = 0; k < 4000; k++) begin
      tick_a = ($urandom % 2) == 0;
      tick_b = ($urandom % 4) == 0;
      rd_addr = 2'($urandom % 4);
      wr_en = ($urandom % 10) == 0;
      wr_addr = 2'($urandom % 4);
      wr_data = $urandom;
      wr_data[10] = ($urandom % 4) != 0;
      wr_data[26] = ($urandom % 4) != 0;
      wr_data[7:4] = 0;
      wr_data[23:20] = 0;
      if (wr_addr == 2'd1) wr_data = $urandom % 8;
      cyc();
    end
    wr_en = 0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule